// File: doc/BRIEF.md
# Two-Wire Write-Only Configuration Receiver

This block is a receive-only target on a two-wire serial bus. It keeps a bank of seven 8-bit control registers that hold the output enables, the frequency source select, a frequency code and the operating mode of a clock generator. The controller sends a start condition, an address byte, two protocol bytes and then data bytes. The block matches the address, acknowledges each byte and writes the data bytes into registers 0 to 6 in order.

Each register bit is updated as soon as its clock pulse completes. No shadow copy is kept, so a transfer may stop after any bit and the registers it did not reach keep their values. Both bus lines are synchronized and majority filtered before the block looks for edges. The open-drain data pad is modelled as a drive-low enable output plus a separate line input. The block also decodes register 0 into the frequency code in use and the mode.

Top module: `serial_cfg_slave`

## Requirements
- R1: After reset the registers hold register 0 = 0x00, register 1 = 0xCF, register 2 = 0x7F, register 3 = 0xFF, register 4 = 0x0F, register 5 = 0x13 and register 6 = 0x00, and `sda_drive_o` is 0. Register k is reported on `cfg_regs_o[8k+7:8k]`.
- R2: The first byte after a start condition is the address, sent MSB first. Only 1101_0010 is accepted. Any other address gets no acknowledge and changes no register until the next start condition.
- R3: The two bytes after an accepted address are acknowledged and their values are discarded. The bytes after those load registers 0, 1, …, 6 in that order, MSB first.
- R4: After the eighth bit of an acknowledged byte, `sda_drive_o` goes to 1 while the clock is low. It stays at 1 through the ninth clock pulse and returns to 0 after that pulse falls.
- R5: A data bit is written to its register bit when the clock pulse that carries it falls. The rest of the byte does not need to arrive first.
- R6: A data change while the clock is high is a start condition (falling data) or a stop condition (rising data). Either one ends the current transfer at once. A bit whose clock pulse is cut short by one of them is not written, and registers the transfer did not reach keep their values.
- R7: Data bytes after the seventh are acknowledged and change no register.
- R8: `mode_o` equals register 0 bits 1:0 (00 normal, 01 test, 10 spread on, 11 all outputs high impedance). `freq_code_o` equals register 0 bits 6:4 when bit 3 is 1 and equals `strap_code_i` when bit 3 is 0.
- R9: A pulse on either line that lasts one clock cycle is filtered out and has no effect on the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_code_i | input | 3 | Frequency code latched from the board straps |
| sda_drive_o | output | 1 | 1 pulls the data line low (acknowledge) |
| cfg_regs_o | output | 56 | Register k on bits 8k+7:8k |
| freq_code_o | output | 3 | Frequency code in use |
| mode_o | output | 2 | Operating mode from register 0 |

## Verification
Complete transfers are driven with the target register index and value varying from a table. The earlier bytes of each transfer are resent with their current values, which shows whether bytes reach the right registers in the right order. A byte is then cut off after four bits, which separates bit-by-bit update from byte-wise update, and a repeated start and an over-long burst confirm that unreached and out-of-range registers stay untouched. Two wrong addresses, one differing in the LSB and one in the MSB, show that the whole address is compared. A one-cycle clock glitch in the middle of a byte would add a bit to the byte if the filter let it through.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam logic [7:0]  DEF_ADDR = 8'b1101_0010;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_TEST   = 2'b01,
    MODE_SPREAD = 2'b10,
    MODE_HIZ    = 2'b11
  } cfgs_mode_e;
endpackage

// File: rtl/cfgs_line_filter.sv
module cfgs_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WIN         = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CNT_W = $clog2(WIN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [WIN-1:0]         win_q;
  logic [CNT_W-1:0]       ones;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      win_q  <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      win_q  <= {win_q[WIN-2:0], sync_q[SYNC_STAGES-1]};
      line_o <= (ones > CNT_W'(WIN / 2));
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < int'(WIN); i++) ones = ones + CNT_W'(win_q[i]);
  end
endmodule

// File: rtl/cfgs_bus_events.sv
module cfgs_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // data edge with clock held high on both samples
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/cfgs_rx_ctrl.sv
module cfgs_rx_ctrl import cfgs_pkg::*; #(
  parameter int unsigned NREG       = 7,
  parameter int unsigned SKIP_BYTES = 2,
  parameter logic [7:0]  SLV_ADDR   = DEF_ADDR,
  localparam int unsigned RIDX_W    = $clog2(NREG),
  localparam int unsigned BIT_W     = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  output logic              wr_en_o,
  output logic [RIDX_W-1:0] wr_reg_o,
  output logic [BIT_W-1:0]  wr_bit_o,
  output logic              wr_val_o,
  output logic              ack_o
);
  localparam int unsigned DATA_BASE = 1 + SKIP_BYTES;
  localparam int unsigned BN_W      = $clog2(DATA_BASE + NREG + 1) + 1;
  localparam logic [BN_W-1:0] BN_MAX = '1;

  logic              in_xfer, addr_ok, in_ack, bit_pend, bit_q;
  logic [BN_W-1:0]   byte_num;
  logic [BIT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] sh_q;
  logic              last_bit, addr_match, in_range;

  assign last_bit   = (bit_cnt == BIT_W'(BYTE_W - 1));
  assign addr_match = ({sh_q, bit_q} == SLV_ADDR);
  assign in_range   = (byte_num >= BN_W'(DATA_BASE)) &&
                      (byte_num <  BN_W'(DATA_BASE + NREG));

  assign wr_en_o  = scl_fall_i & in_xfer & bit_pend & ~in_ack & addr_ok & in_range;
  assign wr_reg_o = RIDX_W'(byte_num - BN_W'(DATA_BASE));
  assign wr_bit_o = BIT_W'(BYTE_W - 1) - bit_cnt;
  assign wr_val_o = bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_xfer  <= 1'b0;
      addr_ok  <= 1'b0;
      in_ack   <= 1'b0;
      bit_pend <= 1'b0;
      bit_q    <= 1'b0;
      byte_num <= '0;
      bit_cnt  <= '0;
      sh_q     <= '0;
      ack_o    <= 1'b0;
    end else if (start_i) begin
      in_xfer  <= 1'b1;
      addr_ok  <= 1'b0;
      in_ack   <= 1'b0;
      bit_pend <= 1'b0;
      byte_num <= '0;
      bit_cnt  <= '0;
      ack_o    <= 1'b0;
    end else if (stop_i) begin
      in_xfer  <= 1'b0;
      in_ack   <= 1'b0;
      bit_pend <= 1'b0;
      ack_o    <= 1'b0;
    end else if (in_xfer) begin
      if (scl_rise_i && !in_ack) begin
        bit_pend <= 1'b1;
        bit_q    <= sda_i;
      end else if (scl_fall_i) begin
        if (in_ack) begin
          in_ack  <= 1'b0;
          ack_o   <= 1'b0;
          bit_cnt <= '0;
          if (byte_num != BN_MAX) byte_num <= byte_num + 1'b1;
        end else if (bit_pend) begin
          // bit is committed only once its clock pulse ends cleanly
          bit_pend <= 1'b0;
          sh_q     <= {sh_q[BYTE_W-3:0], bit_q};
          bit_cnt  <= bit_cnt + 1'b1;
          if (last_bit) begin
            if (byte_num == '0 && !addr_match) begin
              in_xfer <= 1'b0;
            end else begin
              in_ack <= 1'b1;
              ack_o  <= 1'b1;
              if (byte_num == '0) addr_ok <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/cfgs_reg_bank.sv
module cfgs_reg_bank import cfgs_pkg::*; #(
  parameter int unsigned NREG = 7,
  parameter logic [NREG*BYTE_W-1:0] RST_VAL = '0,
  localparam int unsigned RIDX_W = $clog2(NREG),
  localparam int unsigned BIT_W  = $clog2(BYTE_W)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [RIDX_W-1:0]      wr_reg_i,
  input  logic [BIT_W-1:0]       wr_bit_i,
  input  logic                   wr_val_i,
  output logic [NREG*BYTE_W-1:0] regs_o
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [BYTE_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        r_q <= RST_VAL[k*BYTE_W +: BYTE_W];
      else if (wr_en_i && wr_reg_i == RIDX_W'(k))
        r_q[wr_bit_i] <= wr_val_i;
    end
    assign regs_o[k*BYTE_W +: BYTE_W] = r_q;
  end
endmodule

// File: rtl/serial_cfg_slave.sv
module serial_cfg_slave import cfgs_pkg::*; #(
  parameter int unsigned NREG        = 7,
  parameter int unsigned SKIP_BYTES  = 2,
  parameter logic [7:0]  SLV_ADDR    = DEF_ADDR,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_WIN    = 3,
  parameter logic [NREG*BYTE_W-1:0] RST_VAL = 56'h00_13_0F_FF_7F_CF_00,
  localparam int unsigned REGS_W = NREG * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_code_i,
  output logic              sda_drive_o,
  output logic [REGS_W-1:0] cfg_regs_o,
  output logic [2:0]        freq_code_o,
  output logic [1:0]        mode_o
);
  localparam int unsigned RIDX_W = $clog2(NREG);
  localparam int unsigned BIT_W  = $clog2(BYTE_W);

  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic wr_en, wr_val;
  logic [RIDX_W-1:0] wr_reg;
  logic [BIT_W-1:0]  wr_bit;
  cfgs_mode_e        mode;

  cfgs_line_filter #(.SYNC_STAGES(SYNC_STAGES), .WIN(FILT_WIN)) u_flt_scl (
    .clk_i, .rst_ni, .line_i(scl_i), .line_o(scl_f));
  cfgs_line_filter #(.SYNC_STAGES(SYNC_STAGES), .WIN(FILT_WIN)) u_flt_sda (
    .clk_i, .rst_ni, .line_i(sda_i), .line_o(sda_f));

  cfgs_bus_events u_evt (
    .clk_i, .rst_ni, .scl_i(scl_f), .sda_i(sda_f),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev));

  cfgs_rx_ctrl #(.NREG(NREG), .SKIP_BYTES(SKIP_BYTES), .SLV_ADDR(SLV_ADDR)) u_ctrl (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_ev), .stop_i(stop_ev), .sda_i(sda_f),
    .wr_en_o(wr_en), .wr_reg_o(wr_reg), .wr_bit_o(wr_bit), .wr_val_o(wr_val),
    .ack_o(sda_drive_o));

  cfgs_reg_bank #(.NREG(NREG), .RST_VAL(RST_VAL)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_reg_i(wr_reg), .wr_bit_i(wr_bit), .wr_val_i(wr_val),
    .regs_o(cfg_regs_o));

  assign mode        = cfgs_mode_e'(cfg_regs_o[1:0]);
  assign mode_o      = mode;
  assign freq_code_o = cfg_regs_o[3] ? cfg_regs_o[6:4] : strap_code_i;
endmodule

// File: rtl/serial_cfg_slave_chk.sv
module serial_cfg_slave_chk #(
  parameter int unsigned REGS_W = 56
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_f,
  input logic              stop_ev,
  input logic              wr_en,
  input logic              sda_drive_o,
  input logic [REGS_W-1:0] cfg_regs_o
);
  p_ack_on_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_drive_o) |-> !scl_f);

  p_stop_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ev |=> !sda_drive_o);

  p_change_needs_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_regs_o != $past(cfg_regs_o)) |-> $past(wr_en));

  p_one_bit_per_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cfg_regs_o ^ $past(cfg_regs_o)) <= 1);
endmodule

bind serial_cfg_slave serial_cfg_slave_chk #(.REGS_W(REGS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_f(scl_f), .stop_ev(stop_ev),
  .wr_en(wr_en), .sda_drive_o(sda_drive_o), .cfg_regs_o(cfg_regs_o));

// File: tb/serial_cfg_slave_tb.sv
module serial_cfg_slave_tb;
  localparam int H = 10;
  localparam logic [7:0] ADDR = 8'hD2;
  // {target register, value}
  localparam logic [10:0] VEC [6] = '{
    {3'd3, 8'hA5}, {3'd0, 8'h3A}, {3'd6, 8'h5C},
    {3'd1, 8'h00}, {3'd5, 8'hFF}, {3'd0, 8'h01}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] strap = 3'd6;
  logic sda_drive;
  logic [55:0] regs;
  logic [2:0] freq;
  logic [1:0] mode;
  logic [7:0] exp_r [7];
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serial_cfg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(m_sda & ~sda_drive),
    .strap_code_i(strap), .sda_drive_o(sda_drive), .cfg_regs_o(regs),
    .freq_code_o(freq), .mode_o(mode));

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic chk_regs(input string req);
    for (int k = 0; k < 7; k++) chk(regs[k*8 +: 8] == exp_r[k], req, 64'(regs[k*8 +: 8]), 64'(exp_r[k]));
  endtask

  task automatic chk_dec(input string req);
    logic [2:0] ef;
    ef = exp_r[0][3] ? exp_r[0][6:4] : strap;
    chk(freq == ef, req, 64'(freq), 64'(ef));
    chk(mode == exp_r[0][1:0], req, 64'(mode), 64'(exp_r[0][1:0]));
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_c(H);
    m_scl = 1'b1; wait_c(H);
    m_sda = 1'b0; wait_c(H);
    m_scl = 1'b0; wait_c(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_c(H);
    m_scl = 1'b1; wait_c(H);
    m_sda = 1'b1; wait_c(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wait_c(H);
      m_scl = 1'b1; wait_c(H);
      m_scl = 1'b0; wait_c(H);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    m_sda = 1'b1; wait_c(H);
    m_scl = 1'b1; wait_c(H / 2);
    acked = sda_drive;
    wait_c(H / 2);
    m_scl = 1'b0; wait_c(H);
  endtask

  task automatic hdr(input logic [7:0] a, output bit acked);
    bit x;
    bus_start();
    send_byte(a, acked);
    send_byte(8'h5A, x);
    send_byte(8'h03, x);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    bit a;
    logic [7:0] v;
    int idx;
    exp_r = '{8'h00, 8'hCF, 8'h7F, 8'hFF, 8'h0F, 8'h13, 8'h00};
    wait_c(5);
    rst_n = 1'b1;
    wait_c(10);
    chk_regs("R1");
    chk(sda_drive == 1'b0, "R1", 64'(sda_drive), 64'd0);

    // table walk: resend earlier registers with current values, then target
    foreach (VEC[n]) begin
      idx = int'(VEC[n][10:8]);
      v   = VEC[n][7:0];
      bus_start();
      send_byte(ADDR, a);
      chk(a, "R2", 64'(a), 64'd1);
      send_byte(8'hE7, a);
      chk(a, "R3", 64'(a), 64'd1);
      send_byte(8'h18, a);
      chk(a, "R3", 64'(a), 64'd1);
      for (int j = 0; j <= idx; j++) begin
        send_byte((j == idx) ? v : exp_r[j], a);
        chk(a, "R4", 64'(a), 64'd1);
      end
      chk(sda_drive == 1'b0, "R4", 64'(sda_drive), 64'd0);
      exp_r[idx] = v;
      bus_stop();
      wait_c(10);
      chk_regs("R3");
      chk_dec("R8");
    end

    // wrong address: LSB differs, then MSB differs
    for (int w = 0; w < 2; w++) begin
      hdr((w == 0) ? 8'hD3 : 8'h52, a);
      chk(!a, "R2", 64'(a), 64'd0);
      send_byte(8'h00, a);
      chk(!a, "R2", 64'(a), 64'd0);
      send_byte(8'h00, a);
      bus_stop();
      wait_c(10);
      chk_regs("R2");
    end

    // bit-wise update, then stop in mid-byte (reg0 is 0x01 here)
    hdr(ADDR, a);
    send_bits(8'hF0, 4);
    wait_c(H);
    chk(regs[7:0] == 8'hF1, "R5", 64'(regs[7:0]), 64'hF1);
    bus_stop();
    exp_r[0] = 8'hF1;
    wait_c(10);
    chk_regs("R6");

    // repeated start after reg0 ends the transfer; reg1 untouched
    hdr(ADDR, a);
    send_byte(8'h01, a);
    exp_r[0] = 8'h01;
    hdr(ADDR, a);
    chk(a, "R6", 64'(a), 64'd1);
    bus_stop();
    wait_c(10);
    chk_regs("R6");

    // full burst plus extra bytes
    hdr(ADDR, a);
    for (int j = 0; j < 7; j++) begin
      exp_r[j] = 8'h11 * j[7:0] + 8'h02;
      send_byte(exp_r[j], a);
    end
    send_byte(8'hAA, a);
    chk(a, "R7", 64'(a), 64'd1);
    send_byte(8'h55, a);
    chk(a, "R7", 64'(a), 64'd1);
    bus_stop();
    wait_c(10);
    chk_regs("R7");

    // strap path: reg0 = 0x02 has bit3 clear
    strap = 3'd5; wait_c(2);
    chk_dec("R8");
    strap = 3'd2; wait_c(2);
    chk_dec("R8");

    // one-cycle glitch on the clock line in the middle of a byte
    hdr(ADDR, a);
    send_bits(8'h81, 3);
    m_scl = 1'b1; @(negedge clk); m_scl = 1'b0;
    wait_c(H);
    send_bits(8'h81 << 3, 5);
    m_sda = 1'b1; wait_c(H);
    m_scl = 1'b1; wait_c(H / 2);
    a = sda_drive;
    wait_c(H / 2);
    m_scl = 1'b0; wait_c(H);
    chk(a, "R9", 64'(a), 64'd1);
    bus_stop();
    exp_r[0] = 8'h81;
    wait_c(10);
    chk_regs("R9");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule